// File: doc/BRIEF.md
# Guarded NVRAM Write Controller

This block sits between a 32-bit CPU bus and two non-volatile storage windows. One is a byte-wide timekeeper area, the primary window. The other is a word-wide secondary NVRAM area. Writes to the primary window are guarded twice. A persistent enable bit must be set in a small latch bank. A single-use unlock token must also have been armed by a write to a dedicated strobe address. Any write attempt to the primary window uses up the token, whether the write lands or not. Writes to the secondary window need only the enable bit.

The bus is word addressed and single cycle. An access is requested when `busSel` is high, and `busWrite` chooses between a write and a read. Bits 11:10 of the address select the region:
- `00`: latch bank.
- `01`: unlock strobe.
- `10`: primary window.
- `11`: secondary window.

Reads are never gated by the protection state. The latch bank also drives a 2-bit ROM bank select output and holds an identification byte. A blocked write raises a one-cycle pulse together with the address that was refused. The storage arrays are simple internal RAM models with no reset.

Top module: `nvram_guard`

## Requirements
- R1: While reset is asserted the unlock token is disarmed, the enable bit is 0, `romBank` is 0, `blockedPulse` is 0 and `rvalid` is 0.
- R2: A write to the primary window (region `10`, byte index = address bits 7:0) stores `busWdata[7:0]` only when the enable bit is 1 and the unlock token is armed. `busBe` is ignored there.
- R3: Every write attempt to the primary window disarms the unlock token, whether it is accepted or refused.
- R4: The enable bit is bit 0 of latch register 0. A latch write keeps only that bit, and the register reads back with bits 7:1 as 0.
- R5: A write to the secondary window (region `11`, word index = address bits 5:0) depends only on the enable bit. It neither needs nor consumes the unlock token.
- R6: A read of the primary window returns the stored byte in bits 7:0, with bits 31:8 all ones.
- R7: A write of any data to region `01` with address bits 9:0 equal to 0 arms the unlock token. A write to any other address in region `01` has no effect.
- R8: `romBank` equals bits 1:0 of latch register 1. That register reads back with bits 7:2 as 0.
- R9: Latch register 2 is the identification byte. It resets to 0xA0 and is writable. Latch registers 3 to 7 are plain 8-bit latches. All latch reads are zero-extended to 32 bits.
- R10: A refused write leaves the storage unchanged. In the cycle after the refused request, `blockedPulse` is 1 for one cycle and `blockedAddr` holds the refused address.
- R11: On an accepted secondary write, only byte lanes whose `busBe` bit is set are updated (lane b is bits 8b+7:8b).
- R12: Every read returns data with `rvalid` high exactly one cycle after the request, whatever the protection state. Strobe-region reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Word address; bits 11:10 select the region |
| busWdata | input | 32 | Write data |
| busBe | input | 4 | Byte-lane enables (secondary window only) |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| romBank | output | 2 | ROM bank select from latch register 1 |
| blockedPulse | output | 1 | One-cycle pulse after a refused write |
| blockedAddr | output | 12 | Address of the most recent refused write |

## Verification
The guard is exercised with primary writes in every combination of enable bit and token: no strobe, a strobe at the wrong offset, a strobe followed by a secondary write and then a primary write, and repeated writes after one strobe. Together these separate a token that is consumed by any attempt from one that is consumed only on success or by secondary traffic. Enable-register writes with the low bit clear but upper bits set show that only bit 0 counts. Secondary writes with partial lane masks, and reads back after refused writes, show that lanes and contents are kept. A behavioural reference model predicts `rdata`, `rvalid`, `blockedPulse`, `blockedAddr` and `romBank` after every clock.

// File: rtl/nvg_pkg.sv
package nvg_pkg;

  // Region selected by the two top address bits.
  typedef enum logic [1:0] {
    REG_LATCH  = 2'b00,
    REG_STROBE = 2'b01,
    REG_PRI    = 2'b10,
    REG_SEC    = 2'b11
  } region_e;

  // Fixed roles inside the latch bank.
  localparam int EN_IDX   = 0;
  localparam int BANK_IDX = 1;
  localparam int ID_IDX   = 2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    priWe;
    logic    secWe;
    logic    rdEn;
    region_e rdRegion;
  } dpStrobes_t;

endpackage

// File: rtl/nvg_ctrl.sv
module nvg_ctrl
  import nvg_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          LATCH_NUM = 8,
  parameter int          PRI_DEPTH = 256,
  parameter int          SEC_DEPTH = 64,
  parameter logic [7:0]  ID_RESET  = 8'hA0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         busSel,
  input  logic                         busWrite,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [7:0]                   wrByte,
  output dpStrobes_t                   strobes,
  output logic [$clog2(PRI_DEPTH)-1:0] priIdx,
  output logic [$clog2(SEC_DEPTH)-1:0] secIdx,
  output logic [7:0]                   latchRdata,
  output logic [1:0]                   romBank,
  output logic                         blockedPulse,
  output logic [ADDR_W-1:0]            blockedAddr
);

  localparam int LIDX_W = $clog2(LATCH_NUM);
  localparam int PIDX_W = $clog2(PRI_DEPTH);
  localparam int SIDX_W = $clog2(SEC_DEPTH);
  localparam int OFS_W  = ADDR_W - 2;

  region_e           region;
  logic              wrReq;
  logic              rdReq;
  logic              priAttempt;
  logic              secAttempt;
  logic              strobeHit;
  logic              latchWr;
  logic              priAllow;
  logic              secAllow;
  logic              enableBit;
  logic              locked;
  logic [LIDX_W-1:0] lidx;
  logic [7:0]        latchQ [LATCH_NUM];

  // ---------------- decode ----------------
  always_comb begin
    region     = region_e'(busAddr[ADDR_W-1 -: 2]);
    wrReq      = busSel && busWrite;
    rdReq      = busSel && !busWrite;
    lidx       = busAddr[LIDX_W-1:0];
    priIdx     = busAddr[PIDX_W-1:0];
    secIdx     = busAddr[SIDX_W-1:0];
    priAttempt = wrReq && (region == REG_PRI);
    secAttempt = wrReq && (region == REG_SEC);
    latchWr    = wrReq && (region == REG_LATCH);
    strobeHit  = wrReq && (region == REG_STROBE) && (busAddr[OFS_W-1:0] == '0);
  end

  // ---------------- guard ----------------
  assign enableBit = latchQ[EN_IDX][0];
  assign priAllow  = enableBit && !locked;
  assign secAllow  = enableBit;

  always_comb begin
    strobes.priWe    = priAttempt && priAllow;
    strobes.secWe    = secAttempt && secAllow;
    strobes.rdEn     = rdReq;
    strobes.rdRegion = region;
  end

  // Unlock token: locked = 1 means disarmed.
  always_ff @(posedge clk) begin
    if (rst)             locked <= 1'b1;
    else if (strobeHit)  locked <= 1'b0;
    else if (priAttempt) locked <= 1'b1;
  end

  // ---------------- latch bank ----------------
  for (genvar i = 0; i < LATCH_NUM; i++) begin : g_latch
    localparam logic [7:0] MASK = (i == EN_IDX)   ? 8'h01 :
                                  (i == BANK_IDX) ? 8'h03 : 8'hFF;
    localparam logic [7:0] RVAL = (i == ID_IDX)   ? ID_RESET : 8'h00;
    always_ff @(posedge clk) begin
      if (rst)
        latchQ[i] <= RVAL;
      else if (latchWr && (lidx == LIDX_W'(i)))
        latchQ[i] <= wrByte & MASK;
    end
  end

  assign latchRdata = latchQ[lidx];
  assign romBank    = latchQ[BANK_IDX][1:0];

  // ---------------- refused-write report ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      blockedPulse <= 1'b0;
      blockedAddr  <= '0;
    end else begin
      blockedPulse <= (priAttempt && !priAllow) || (secAttempt && !secAllow);
      if ((priAttempt && !priAllow) || (secAttempt && !secAllow))
        blockedAddr <= busAddr;
    end
  end

  // ---------------- assertions ----------------
  p_relock_r3: assert property (@(posedge clk) disable iff (rst)
    priAttempt |=> locked);

  p_unlock_r7: assert property (@(posedge clk) disable iff (rst)
    strobeHit |=> !locked);

  p_en_bit0_r4: assert property (@(posedge clk) disable iff (rst)
    (latchWr && (lidx == LIDX_W'(EN_IDX))) |=> (enableBit == $past(wrByte[0])));

  p_bank_out_r8: assert property (@(posedge clk) disable iff (rst)
    (latchWr && (lidx == LIDX_W'(BANK_IDX))) |=> (romBank == $past(wrByte[1:0])));

  p_blocked_src_r10: assert property (@(posedge clk) disable iff (rst)
    blockedPulse |-> $past(wrReq));

  p_no_guarded_write_r2: assert property (@(posedge clk) disable iff (rst)
    (priAttempt && locked) |=> !$past(strobes.priWe));

endmodule

// File: rtl/nvg_datapath.sv
module nvg_datapath
  import nvg_pkg::*;
#(
  parameter int PRI_DEPTH = 256,
  parameter int SEC_DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  dpStrobes_t                   strobes,
  input  logic [$clog2(PRI_DEPTH)-1:0] priIdx,
  input  logic [$clog2(SEC_DEPTH)-1:0] secIdx,
  input  logic [31:0]                  busWdata,
  input  logic [3:0]                   busBe,
  input  logic [7:0]                   latchRdata,
  output logic [31:0]                  rdata,
  output logic                         rvalid
);

  localparam int LANES = 4;

  logic [7:0]  priMem [PRI_DEPTH];
  logic [31:0] secRd;

  // Primary byte array: byte lane 0 only.
  always_ff @(posedge clk) begin
    if (strobes.priWe)
      priMem[priIdx] <= busWdata[7:0];
  end

  // Secondary word array, one bank per byte lane.
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] laneMem [SEC_DEPTH];
    always_ff @(posedge clk) begin
      if (strobes.secWe && busBe[b])
        laneMem[secIdx] <= busWdata[8*b +: 8];
    end
    assign secRd[8*b +: 8] = laneMem[secIdx];
  end

  // Registered read return, fixed one-cycle latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= strobes.rdEn;
      if (strobes.rdEn) begin
        case (strobes.rdRegion)
          REG_LATCH:  rdata <= {24'h000000, latchRdata};
          REG_STROBE: rdata <= '0;
          REG_PRI:    rdata <= {24'hFFFFFF, priMem[priIdx]};
          default:    rdata <= secRd;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  p_rd_latency_r12: assert property (@(posedge clk) disable iff (rst)
    strobes.rdEn |=> rvalid);

  p_no_spurious_rd_r12: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(strobes.rdEn));

  p_pri_pad_r6: assert property (@(posedge clk) disable iff (rst)
    (rvalid && $past(strobes.rdRegion == REG_PRI)) |-> (rdata[31:8] == 24'hFFFFFF));

  p_one_write_r2: assert property (@(posedge clk) disable iff (rst)
    !(strobes.priWe && strobes.secWe));

endmodule

// File: rtl/nvram_guard.sv
module nvram_guard
  import nvg_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter int         LATCH_NUM = 8,
  parameter int         PRI_DEPTH = 256,
  parameter int         SEC_DEPTH = 64,
  parameter logic [7:0] ID_RESET  = 8'hA0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [3:0]        busBe,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic [1:0]        romBank,
  output logic              blockedPulse,
  output logic [ADDR_W-1:0] blockedAddr
);

  localparam int PIDX_W = $clog2(PRI_DEPTH);
  localparam int SIDX_W = $clog2(SEC_DEPTH);

  dpStrobes_t        strobes;
  logic [PIDX_W-1:0] priIdx;
  logic [SIDX_W-1:0] secIdx;
  logic [7:0]        latchRdata;

  nvg_ctrl #(
    .ADDR_W    (ADDR_W),
    .LATCH_NUM (LATCH_NUM),
    .PRI_DEPTH (PRI_DEPTH),
    .SEC_DEPTH (SEC_DEPTH),
    .ID_RESET  (ID_RESET)
  ) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .busSel       (busSel),
    .busWrite     (busWrite),
    .busAddr      (busAddr),
    .wrByte       (busWdata[7:0]),
    .strobes      (strobes),
    .priIdx       (priIdx),
    .secIdx       (secIdx),
    .latchRdata   (latchRdata),
    .romBank      (romBank),
    .blockedPulse (blockedPulse),
    .blockedAddr  (blockedAddr)
  );

  nvg_datapath #(
    .PRI_DEPTH (PRI_DEPTH),
    .SEC_DEPTH (SEC_DEPTH)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .priIdx     (priIdx),
    .secIdx     (secIdx),
    .busWdata   (busWdata),
    .busBe      (busBe),
    .latchRdata (latchRdata),
    .rdata      (rdata),
    .rvalid     (rvalid)
  );

endmodule

// File: tb/test_nvram_guard.sv
`timescale 1ns/1ps
module test_nvram_guard;

  logic        clk = 1'b0;
  logic        rst;
  logic        busSel, busWrite;
  logic [11:0] busAddr;
  logic [31:0] busWdata;
  logic [3:0]  busBe;
  logic [31:0] rdata;
  logic        rvalid;
  logic [1:0]  romBank;
  logic        blockedPulse;
  logic [11:0] blockedAddr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  nvram_guard i_nvram_guard (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busBe(busBe),
    .rdata(rdata), .rvalid(rvalid), .romBank(romBank),
    .blockedPulse(blockedPulse), .blockedAddr(blockedAddr)
  );

  // Reference model state
  bit          mLocked;
  logic [7:0]  mLatch [8];
  logic [7:0]  mPri [256];
  logic [31:0] mSec [64];
  bit          eRvalid, ePulse;
  logic [31:0] eRdata;
  logic [11:0] eAddr;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mLocked = 1;
    foreach (mLatch[i]) mLatch[i] = 8'h00;
    mLatch[2] = 8'hA0;
    eRvalid = 0; ePulse = 0; eAddr = '0; eRdata = '0;
  endtask

  task automatic modelStep(input bit sel, input bit wr, input logic [11:0] a,
                           input logic [31:0] d, input logic [3:0] be);
    bit en;
    en = mLatch[0][0];
    eRvalid = sel && !wr;
    ePulse  = 0;
    if (sel && !wr) begin
      case (a[11:10])
        2'b00: eRdata = {24'h0, mLatch[a[2:0]]};
        2'b01: eRdata = 32'h0;
        2'b10: eRdata = {24'hFFFFFF, mPri[a[7:0]]};
        default: eRdata = mSec[a[5:0]];
      endcase
    end else if (sel && wr) begin
      case (a[11:10])
        2'b00: begin
          if (a[2:0] == 0)      mLatch[0] = d[7:0] & 8'h01;
          else if (a[2:0] == 1) mLatch[1] = d[7:0] & 8'h03;
          else                  mLatch[a[2:0]] = d[7:0];
        end
        2'b01: if (a[9:0] == 0) mLocked = 0;
        2'b10: begin
          if (en && !mLocked) mPri[a[7:0]] = d[7:0];
          else begin ePulse = 1; eAddr = a; end
          mLocked = 1;
        end
        default: begin
          if (en) begin
            for (int b = 0; b < 4; b++)
              if (be[b]) mSec[a[5:0]][8*b +: 8] = d[8*b +: 8];
          end else begin ePulse = 1; eAddr = a; end
        end
      endcase
    end
  endtask

  // One bus cycle: drive at negedge, step the model at posedge, compare at next negedge.
  task automatic cyc(input bit sel, input bit wr, input logic [11:0] a,
                     input logic [31:0] d, input logic [3:0] be, input string tag);
    busSel = sel; busWrite = wr; busAddr = a; busWdata = d; busBe = be;
    @(posedge clk);
    modelStep(sel, wr, a, d, be);
    @(negedge clk);
    busSel = 0; busWrite = 0;
    check({"R12 rvalid ", tag}, {31'h0, rvalid}, {31'h0, eRvalid});
    if (eRvalid && !$isunknown(eRdata)) check({"rdata ", tag}, rdata, eRdata);
    check({"R10 pulse ", tag}, {31'h0, blockedPulse}, {31'h0, ePulse});
    if (ePulse) check({"R10 addr ", tag}, {20'h0, blockedAddr}, {20'h0, eAddr});
    check({"R8 romBank ", tag}, {30'h0, romBank}, {30'h0, mLatch[1][1:0]});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be, input string tag);
    cyc(1, 1, a, d, be, tag);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1, 0, a, 32'h0, 4'h0, tag);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    foreach (mPri[i]) mPri[i] = 'x;
    foreach (mSec[i]) mSec[i] = 'x;
    modelReset();
    rst = 1; busSel = 0; busWrite = 0; busAddr = 0; busWdata = 0; busBe = 0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 romBank", {30'h0, romBank}, 32'h0);
    check("R1 pulse", {31'h0, blockedPulse}, 32'h0);
    check("R1 rvalid", {31'h0, rvalid}, 32'h0);
    rst = 0;
    rd(12'h002, "R9 id reset");
    rd(12'h000, "R1 enable reset");
    // R1/R2: token armed but enable clear -> refused
    wr(12'h400, 32'h0, 4'h0, "R7 strobe");
    wr(12'h805, 32'h11, 4'hF, "R2 enable clear");
    // set enable
    wr(12'h000, 32'h1, 4'hF, "R4 set enable");
    // R3: token already consumed by refused write
    wr(12'h805, 32'h22, 4'hF, "R3 consumed by refusal");
    wr(12'h400, 32'hDEADBEEF, 4'h0, "R7 strobe any data");
    wr(12'h805, 32'h3C, 4'hF, "R2 accepted");
    rd(12'h805, "R6 pad");
    wr(12'h805, 32'h77, 4'hF, "R3 second write refused");
    rd(12'h805, "R10 unchanged");
    // R7: strobe at non-zero offset has no effect
    wr(12'h401, 32'h0, 4'h0, "R7 wrong offset");
    wr(12'h807, 32'h55, 4'hF, "R7 still locked");
    rd(12'h807, "R10 unknown kept");
    // R5: secondary write does not consume the token
    wr(12'h400, 32'h0, 4'h0, "R7 strobe");
    wr(12'hC03, 32'hA1B2C3D4, 4'hF, "R5 sec full");
    wr(12'h806, 32'h81, 4'hF, "R5 token kept");
    rd(12'h806, "R6 pad 81");
    rd(12'hC03, "R5 sec read");
    // R11: byte lanes
    wr(12'hC03, 32'h11223344, 4'b0101, "R11 lanes 0,2");
    rd(12'hC03, "R11 partial");
    wr(12'hC03, 32'hFFFFFFFF, 4'b1000, "R11 lane 3");
    rd(12'hC03, "R11 lane 3 read");
    // R4: upper bits ignored
    wr(12'h000, 32'hFE, 4'hF, "R4 upper bits only");
    rd(12'h000, "R4 readback");
    wr(12'hC03, 32'h0, 4'hF, "R5 sec refused");
    rd(12'hC03, "R10 sec unchanged");
    wr(12'h400, 32'h0, 4'h0, "R7 strobe");
    wr(12'h808, 32'h99, 4'hF, "R4 enable clear refuses");
    wr(12'h000, 32'h03, 4'hF, "R4 set bit0");
    rd(12'h000, "R4 readback 1");
    // R8: bank select
    wr(12'h001, 32'hFF, 4'hF, "R8 bank 3");
    rd(12'h001, "R8 readback");
    wr(12'h001, 32'h02, 4'hF, "R8 bank 2");
    // R9: id writable, plain latches
    wr(12'h002, 32'h55, 4'hF, "R9 id write");
    rd(12'h002, "R9 id read");
    wr(12'h007, 32'hC7, 4'hF, "R9 plain latch");
    rd(12'h007, "R9 plain read");
    // R12: back-to-back reads, strobe region read
    rd(12'h805, "R12 b2b 1");
    rd(12'h806, "R12 b2b 2");
    rd(12'h400, "R12 strobe read");
    cyc(0, 0, 12'h0, 32'h0, 4'h0, "R12 idle");
    done = 1;
    finishRun();
  end

endmodule